// File: doc/BRIEF.md
# ALU with condition flags

A 64-bit combinational arithmetic-logic unit for a small load/store processor core. Every cycle it combines a first operand with either a second register operand or a zero-extended immediate supplied by the caller. A three-bit operation code selects add, subtract, bitwise AND, OR, XOR, or a logical shift left or right by a six-bit amount. The 64-bit result is purely combinational.

Beside the result the unit keeps a registered four-bit condition state: negative, zero, signed overflow and carry. It changes only on a clock edge where the caller asks for flag setting and the operation is add, subtract or AND. A compare is issued as a flag-setting subtract whose result the caller discards.

Top module: `alu_flags`

## Requirements
- R1: With op_i = 0 (add), result_o equals op_a_i plus the second operand, modulo 2^64.
- R2: With op_i = 1 (subtract), result_o equals op_a_i minus the second operand, modulo 2^64.
- R3: op_i = 2, 3 and 4 give the bitwise AND, OR and XOR of op_a_i and the second operand.
- R4: op_i = 5 shifts op_a_i left and op_i = 6 shifts it right by shamt_i (0 to 63) places, filling with zeros; the second operand is not used.
- R5: The second operand is imm_i when use_imm_i is 1 and op_b_i when it is 0.
- R6: On a flag update, flags_o[3] (negative) takes bit 63 of the result and flags_o[2] (zero) is 1 exactly when the result is all zeros.
- R7: On a flag update, flags_o[0] (carry) is the carry out of bit 63 for add, and for subtract is 1 exactly when op_a_i >= second operand, unsigned.
- R8: On a flag update, flags_o[1] (overflow) is 1 exactly when the add or subtract overflows as a signed 64-bit operation.
- R9: A flag-setting AND clears the overflow and carry flags.
- R10: flags_o is loaded on the rising clock edge only when set_flags_i is 1 and op_i is 0, 1 or 2; otherwise it holds its value.
- R11: rst_ni low clears flags_o to 0 asynchronously.
- R12: op_i = 7 gives a result of zero and never updates the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the flag register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Operation code |
| op_a_i | input | 64 | First operand |
| op_b_i | input | 64 | Second register operand |
| imm_i | input | 64 | Zero-extended immediate operand |
| use_imm_i | input | 1 | Select immediate as second operand |
| shamt_i | input | 6 | Shift amount |
| set_flags_i | input | 1 | Request flag update |
| result_o | output | 64 | Operation result |
| flags_o | output | 4 | Flags {negative, zero, overflow, carry} |

## Verification
The only internal state is the flag register, so a wrong flag value appears on flags_o one cycle after the flag-setting operation that wrote it and then persists unchanged through every non-setting cycle that follows. The bench therefore compares flags after each operation, including long runs of OR, XOR, shift and non-setting cycles, so that a spurious load or a missed load shows within one cycle. Carry and overflow are driven hard with operands at the signed and unsigned boundaries, where an inverted borrow or a misplaced sign test differs from the correct value.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_ORR = 3'd3,
    OP_XOR = 3'd4,
    OP_LSL = 3'd5,
    OP_LSR = 3'd6,
    OP_NUL = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } alu_flags_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   ext;

  // subtract as a + ~b + 1; carry out then means no borrow
  assign b_eff   = sub_i ? ~b_i : b_i;
  assign ext     = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
  assign sum_o   = ext[W-1:0];
  assign carry_o = ext[W];
  assign ovf_o   = (a_i[W-1] == b_eff[W-1]) && (ext[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W    = 64,
  parameter bit LEFT = 1'b1,
  localparam int SW  = $clog2(W)
) (
  input  logic [W-1:0]  d_i,
  input  logic [SW-1:0] amt_i,
  output logic [W-1:0]  q_o
);
  logic [W-1:0] st [SW+1];

  assign st[0] = d_i;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    if (LEFT) begin : g_l
      assign st[k+1] = amt_i[k] ? (st[k] << STEP) : st[k];
    end else begin : g_r
      assign st[k+1] = amt_i[k] ? (st[k] >> STEP) : st[k];
    end
  end

  assign q_o = st[SW];
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  alu_flags_t d_i,
  output alu_flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_pkg::*;
#(
  parameter int W   = 64,
  localparam int SW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    op_i,
  input  logic [W-1:0]  op_a_i,
  input  logic [W-1:0]  op_b_i,
  input  logic [W-1:0]  imm_i,
  input  logic          use_imm_i,
  input  logic [SW-1:0] shamt_i,
  input  logic          set_flags_i,
  output logic [W-1:0]  result_o,
  output logic [3:0]    flags_o
);
  alu_op_e      op;
  logic [W-1:0] b_sel, sum, shl, shr;
  logic         carry, ovf, arith, flag_op;
  alu_flags_t   flag_d, flag_q;

  assign op    = alu_op_e'(op_i);
  assign b_sel = use_imm_i ? imm_i : op_b_i;

  alu_addsub #(.W(W)) i_addsub (
    .a_i    (op_a_i),
    .b_i    (b_sel),
    .sub_i  (op == OP_SUB),
    .sum_o  (sum),
    .carry_o(carry),
    .ovf_o  (ovf)
  );

  alu_shift #(.W(W), .LEFT(1'b1)) i_shl (.d_i(op_a_i), .amt_i(shamt_i), .q_o(shl));
  alu_shift #(.W(W), .LEFT(1'b0)) i_shr (.d_i(op_a_i), .amt_i(shamt_i), .q_o(shr));

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: result_o = sum;
      OP_AND:         result_o = op_a_i & b_sel;
      OP_ORR:         result_o = op_a_i | b_sel;
      OP_XOR:         result_o = op_a_i ^ b_sel;
      OP_LSL:         result_o = shl;
      OP_LSR:         result_o = shr;
      default:        result_o = '0;
    endcase
  end

  assign arith   = (op == OP_ADD) || (op == OP_SUB);
  assign flag_op = set_flags_i && (arith || (op == OP_AND));

  always_comb begin
    flag_d.n = result_o[W-1];
    flag_d.z = ~|result_o;
    flag_d.v = arith & ovf;
    flag_d.c = arith & carry;
  end

  alu_flag_reg i_flag_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (flag_op),
    .d_i   (flag_d),
    .q_o   (flag_q)
  );

  assign flags_o = flag_q;
endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk #(
  parameter int W   = 64,
  localparam int SW = $clog2(W)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [2:0]    op_i,
  input logic [W-1:0]  op_a_i,
  input logic [SW-1:0] shamt_i,
  input logic          set_flags_i,
  input logic [W-1:0]  result_o,
  input logic [3:0]    flags_o
);
  logic upd;
  assign upd = set_flags_i && (op_i <= 3'd2);

  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd |=> $stable(flags_o)); // R10
  AST_FLAG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> flags_o[2] == ($past(result_o) == '0)); // R6
  AST_FLAG_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> flags_o[3] == $past(result_o[W-1])); // R6
  AST_AND_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_flags_i && op_i == 3'd2) |=> flags_o[1:0] == 2'b00); // R9
  AST_SHIFT_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i inside {3'd5, 3'd6} && shamt_i == '0) |-> result_o == op_a_i); // R4
  AST_NULL_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd7 |-> result_o == '0); // R12
endmodule

bind alu_flags alu_flags_chk #(.W(W)) i_alu_flags_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_i       (op_i),
  .op_a_i     (op_a_i),
  .shamt_i    (shamt_i),
  .set_flags_i(set_flags_i),
  .result_o   (result_o),
  .flags_o    (flags_o)
);

// File: tb/test_alu_flags.sv
module test_alu_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = '0;
  logic [63:0] a = '0, b = '0, imm = '0;
  logic        use_imm = 1'b0, sf = 1'b0;
  logic [5:0]  sh = '0;
  logic [63:0] res;
  logic [3:0]  flg;
  logic [3:0]  model = '0;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  alu_flags i_alu_flags (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .op_a_i(a), .op_b_i(b),
    .imm_i(imm), .use_imm_i(use_imm), .shamt_i(sh), .set_flags_i(sf),
    .result_o(res), .flags_o(flg)
  );

  function automatic logic [63:0] exp_res(logic [2:0] o, logic [63:0] x, logic [63:0] y, logic [5:0] s);
    case (o)
      3'd0: return x + y;
      3'd1: return x - y;
      3'd2: return x & y;
      3'd3: return x | y;
      3'd4: return x ^ y;
      3'd5: return x << s;
      3'd6: return x >> s;
      default: return 64'd0;
    endcase
  endfunction

  function automatic logic [3:0] exp_flags(logic [2:0] o, logic [63:0] x, logic [63:0] y, logic [63:0] r);
    logic [64:0] s65;
    logic v, c;
    v = 1'b0; c = 1'b0;
    if (o == 3'd0) begin
      s65 = {1'b0, x} + {1'b0, y};
      c = s65[64];
      v = (x[63] == y[63]) && (r[63] != x[63]);
    end else if (o == 3'd1) begin
      c = (x >= y);
      v = (x[63] != y[63]) && (r[63] != x[63]);
    end
    return {r[63], r == 64'd0, v, c};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one operation: result checked mid-cycle, flags after the next edge
  task automatic run(string req, logic [2:0] o, logic [63:0] x, logic [63:0] y,
                     logic [63:0] im, logic ui, logic [5:0] s, logic f);
    logic [63:0] ysel, er;
    @(negedge clk);
    op = o; a = x; b = y; imm = im; use_imm = ui; sh = s; sf = f;
    ysel = ui ? im : y;
    er = exp_res(o, x, ysel, s);
    #1 check({req, " result"}, res, er);
    if (f && o <= 3'd2) model = exp_flags(o, x, ysel, er);
    @(posedge clk);
    #1 check({req, " flags"}, {60'd0, flg}, {60'd0, model});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] k [6];
    k[0] = 64'd0; k[1] = 64'd1; k[2] = '1;
    k[3] = 64'h7fff_ffff_ffff_ffff; k[4] = 64'h8000_0000_0000_0000; k[5] = 64'h0000_0000_ffff_ffff;
    void'($urandom(32'd2024));
    repeat (2) @(posedge clk);
    #1 check("R11 reset", {60'd0, flg}, 64'd0);
    rst_n = 1'b1;

    // R1 R7 R8 add corners
    run("R1 R7 add carry", 3'd0, '1, 64'd1, 0, 0, 0, 1);
    run("R8 add ovf", 3'd0, k[3], 64'd1, 0, 0, 0, 1);
    run("R8 add neg ovf", 3'd0, k[4], k[4], 0, 0, 0, 1);
    // R2 R7 compare corners
    run("R2 R7 sub eq", 3'd1, 64'd5, 64'd5, 0, 0, 0, 1);
    run("R7 sub borrow", 3'd1, 64'd3, 64'd5, 0, 0, 0, 1);
    run("R8 sub ovf", 3'd1, k[4], 64'd1, 0, 0, 0, 1);
    // R5 immediate form
    run("R5 addi", 3'd0, 64'd100, 64'hdead, 64'd7, 1, 0, 1);
    run("R5 subi", 3'd1, 64'd7, 64'd0, 64'd15, 1, 0, 1);
    // R9 AND flag clears V,C after they were set
    run("R8 setup", 3'd0, k[4], k[4], 0, 0, 0, 1);
    run("R9 andi", 3'd2, '1, 0, 64'h80, 1, 0, 1);
    run("R9 and zero", 3'd2, k[4], k[3], 0, 0, 0, 1);
    // R3 R10 logic ops leave flags even with sf set
    run("R3 R10 orr", 3'd3, 64'hf0, 64'h0f, 0, 0, 0, 1);
    run("R3 R10 xor", 3'd4, '1, '1, 0, 0, 0, 1);
    run("R10 add no sf", 3'd0, 64'd0, 64'd0, 0, 0, 0, 0);
    // R4 shifts
    run("R4 lsl 0", 3'd5, k[5], 0, 0, 0, 6'd0, 1);
    run("R4 lsl 63", 3'd5, '1, 0, 0, 0, 6'd63, 1);
    run("R4 lsr 63", 3'd6, k[4], 0, 0, 0, 6'd63, 0);
    run("R4 lsr 32", 3'd6, '1, '1, 0, 0, 6'd32, 1);
    // R12 null op
    run("R12 null", 3'd7, '1, '1, 0, 0, 0, 1);

    // R11 async reset mid-run
    run("R11 setup", 3'd1, 64'd1, 64'd2, 0, 0, 0, 1);
    @(negedge clk); rst_n = 1'b0; model = '0;
    #1 check("R11 async clear", {60'd0, flg}, 64'd0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 400; i++) begin
      logic [63:0] x, y, im;
      x  = ($urandom % 3 == 0) ? k[$urandom % 6] : {$urandom, $urandom};
      y  = ($urandom % 3 == 0) ? k[$urandom % 6] : {$urandom, $urandom};
      im = {52'd0, 12'($urandom)};
      run("R1 R2 R3 R4 R5 R6 R7 R8 R10 random", 3'($urandom), x, y, im,
          1'($urandom), 6'($urandom), 1'($urandom));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule